// File: doc/BRIEF.md
# First-Address Latching Sequencer

This block is the device-side front end of a synchronous flash. It picks up the starting read address without any address strobe. When the ready line rises, and the address-latch, device-reset and output-enable controls are all at their required levels, the block runs a four-cycle sequence. During that sequence it drives a fixed sync/dummy word onto the data bus. It samples the 23-bit address bus on the third sequence edge, and when the sequence finishes it hands the address to the burst-read logic together with a one-cycle start strobe.

Which event starts a sequence depends on history. Until one sequence has completed after power-on, a sequence starts on whichever comes last: the ready line rising or output-enable falling. Once a sequence has completed, only a rising ready line starts one. A sequence is abandoned if any control leaves its level. It is also abandoned when ready drops while a configuration bit asks for that.

All control inputs pass through a two-flop synchronizer before edge detection. The address bus is sampled directly, because the host holds it stable around the capture edge.

Top module: `first_addr_latch`

## Requirements
- R1: While `rst_n` is low, and after it is released, the block is idle: `busy_o`=0, `start_rd_o`=0, `data_oe_o`=0, `data_o`=0, `cap_addr_o`=0. The power-on trigger rule (R4) is in force again after every reset.
- R2: A trigger is first seen on the second rising clock edge after the input changes, because of the two synchronizer flops. The first sequence edge is the third rising edge, and `busy_o` is high from that edge onward.
- R3: A sequence starts only if, at the trigger, `lat_i`=1, `dev_rst_n_i`=1 and `oe_n_i`=0. A trigger that arrives without all three starts nothing.
- R4: Until one sequence has completed after reset, a falling `oe_n_i` while ready is already high starts a sequence, just as a rising ready does.
- R5: After a completed sequence, a falling `oe_n_i` starts nothing. Only a rising `rdy_i` starts a sequence.
- R6: A sequence keeps `busy_o` high for exactly 4 cycles. During those cycles `data_oe_o`=1 and `data_o`=16'hFFFF. At all other times `data_oe_o`=0 and `data_o`=0.
- R7: The address captured is the value on `addr_i` at the third sequence edge, where the edge that starts the sequence counts as the first.
- R8: At the edge that ends the fourth busy cycle, `start_rd_o` goes high for exactly one cycle. `cap_addr_o` takes the captured address at that same edge and holds it until the next completed sequence.
- R9: If `lat_i`, `dev_rst_n_i` or `oe_n_i` leaves its required level during a sequence, the block returns to idle. It gives no `start_rd_o` pulse and leaves `cap_addr_o` unchanged, even if the capture edge has already passed.
- R10: A low `rdy_i` during a sequence aborts it as in R9 when `cfg_rdy_abort_i`=1. When `cfg_rdy_abort_i`=0, a low `rdy_i` has no effect and the sequence completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequence clock |
| rst_n | input | 1 | Asynchronous active-low block reset, released synchronously |
| rdy_i | input | 1 | Ready line, asynchronous |
| lat_i | input | 1 | Address-latch control; must be high |
| dev_rst_n_i | input | 1 | Device reset control; must be high (inactive) |
| oe_n_i | input | 1 | Output enable, active low |
| cfg_rdy_abort_i | input | 1 | Configuration bit: a low ready line aborts a running sequence |
| addr_i | input | 23 | Address bus |
| data_o | output | 16 | Data bus value |
| data_oe_o | output | 1 | Data bus drive enable |
| busy_o | output | 1 | Sequence in progress |
| cap_addr_o | output | 23 | Captured start address |
| start_rd_o | output | 1 | One-cycle start-read strobe |

## Verification
The assertions assume two things. First, `cfg_rdy_abort_i` is quasi-static: it changes only while no sequence is running. Second, the control inputs stay put long enough to pass the two synchronizer flops, so no pulse shorter than a clock period is expected to register. The stimulus changes every control input only at falling clock edges and holds each level for several cycles. It sets the configuration bit only between sequences. It changes `addr_i` at every falling edge during a sequence, so only a capture on the correct edge matches the expected value.

// File: rtl/fal_pkg.sv
package fal_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fal_state_e;

  // Positions of the controls inside the synchronized vector.
  localparam int unsigned CI_RDY = 0;
  localparam int unsigned CI_LAT = 1;
  localparam int unsigned CI_RST = 2;
  localparam int unsigned CI_OEN = 3;
  localparam int unsigned CI_NUM = 4;
endpackage

// File: rtl/fal_rst_sync.sv
module fal_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/fal_sync.sv
module fal_sync #(
  parameter int unsigned W      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= d_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg_q[s] <= '0;
        else        stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/fal_trig.sv
module fal_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic rdy_s_i,
  input  logic lat_s_i,
  input  logic rst_s_i,
  input  logic oen_s_i,
  input  logic done_i,
  output logic ctl_ok_o,
  output logic start_o
);
  logic rdy_q, oen_q, por_q;
  logic rdy_rise, oen_fall, por_d;

  assign rdy_rise = rdy_s_i & ~rdy_q;
  assign oen_fall = ~oen_s_i & oen_q;
  assign ctl_ok_o = lat_s_i & rst_s_i & ~oen_s_i;
  assign start_o  = ctl_ok_o & rdy_s_i & (rdy_rise | (por_q & oen_fall));

  always_comb begin
    por_d = por_q;
    if (done_i) por_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= 1'b0;
      oen_q <= 1'b0;
      por_q <= 1'b1;
    end else begin
      rdy_q <= rdy_s_i;
      oen_q <= oen_s_i;
      por_q <= por_d;
    end
  end

  // R5: once the power-on flag is gone, only a ready rise may start
  p_oe_no_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!por_q && !(rdy_s_i && !rdy_q)) |-> !start_o);
  // R3: never start with a control out of level
  p_start_needs_ctl_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> (lat_s_i && rst_s_i && !oen_s_i && rdy_s_i));
endmodule

// File: rtl/fal_seq.sv
module fal_seq
  import fal_pkg::*;
#(
  parameter int unsigned AW        = 23,
  parameter int unsigned DW        = 16,
  parameter int unsigned SEQ_LEN   = 4,
  parameter int unsigned CAP_EDGE  = 3,
  parameter logic [DW-1:0] SYNC_WORD = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ctl_ok_i,
  input  logic          rdy_s_i,
  input  logic          cfg_rdy_abort_i,
  input  logic [AW-1:0] addr_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          start_rd_o,
  output logic [AW-1:0] cap_addr_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  localparam int unsigned CW      = (SEQ_LEN > 1) ? $clog2(SEQ_LEN) : 1;
  localparam logic [CW-1:0] LAST  = CW'(SEQ_LEN - 1);
  localparam logic [CW-1:0] CAPIX = CW'(CAP_EDGE - 2);

  fal_state_e    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [AW-1:0] stage_q, cap_q;
  logic          stage_en, fin, abort, pulse_q;

  assign abort = ~ctl_ok_i | (~rdy_s_i & cfg_rdy_abort_i);

  always_comb begin
    st_d     = st_q;
    cnt_d    = cnt_q;
    stage_en = 1'b0;
    fin      = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d  = ST_RUN;
          cnt_d = '0;
        end
      end
      ST_RUN: begin
        if (abort) begin
          st_d = ST_IDLE;
        end else if (cnt_q == LAST) begin
          st_d = ST_IDLE;
          fin  = 1'b1;
        end else begin
          cnt_d    = cnt_q + 1'b1;
          stage_en = (cnt_q == CAPIX);
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      pulse_q <= fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= addr_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cap_q <= '0;
    else if (fin) cap_q <= stage_q;
  end

  assign busy_o     = (st_q == ST_RUN);
  assign done_o     = fin;
  assign start_rd_o = pulse_q;
  assign cap_addr_o = cap_q;
  assign data_oe_o  = busy_o;
  assign data_o     = busy_o ? SYNC_WORD : '0;

  // R8: strobe lasts one cycle and follows a running sequence
  p_pulse_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd_o |=> !start_rd_o);
  p_pulse_after_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start_rd_o |-> $past(st_q == ST_RUN));
  // R9: control loss returns to idle without a strobe
  p_ctl_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !ctl_ok_i) |=> (st_q == ST_IDLE && !start_rd_o));
  // R9: captured address moves only together with the strobe
  p_cap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(cap_addr_o) |-> start_rd_o);
  // R10: ready low aborts when configured
  p_rdy_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !rdy_s_i && cfg_rdy_abort_i) |=> !start_rd_o);
endmodule

// File: rtl/first_addr_latch.sv
module first_addr_latch
  import fal_pkg::*;
#(
  parameter int unsigned AW          = 23,
  parameter int unsigned DW          = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SEQ_LEN     = 4,
  parameter int unsigned CAP_EDGE    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rdy_i,
  input  logic          lat_i,
  input  logic          dev_rst_n_i,
  input  logic          oe_n_i,
  input  logic          cfg_rdy_abort_i,
  input  logic [AW-1:0] addr_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          busy_o,
  output logic [AW-1:0] cap_addr_o,
  output logic          start_rd_o
);
  logic              rst_sn;
  logic [CI_NUM-1:0] ctl_raw, ctl_s;
  logic              ctl_ok, start, done;

  fal_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_n_o(rst_sn)
  );

  always_comb begin
    ctl_raw         = '0;
    ctl_raw[CI_RDY] = rdy_i;
    ctl_raw[CI_LAT] = lat_i;
    ctl_raw[CI_RST] = dev_rst_n_i;
    ctl_raw[CI_OEN] = oe_n_i;
  end

  fal_sync #(.W(CI_NUM), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sn), .d_i(ctl_raw), .q_o(ctl_s)
  );

  fal_trig u_trig (
    .clk(clk), .rst_n(rst_sn),
    .rdy_s_i(ctl_s[CI_RDY]), .lat_s_i(ctl_s[CI_LAT]),
    .rst_s_i(ctl_s[CI_RST]), .oen_s_i(ctl_s[CI_OEN]),
    .done_i(done), .ctl_ok_o(ctl_ok), .start_o(start)
  );

  fal_seq #(
    .AW(AW), .DW(DW), .SEQ_LEN(SEQ_LEN), .CAP_EDGE(CAP_EDGE)
  ) u_seq (
    .clk(clk), .rst_n(rst_sn),
    .start_i(start), .ctl_ok_i(ctl_ok), .rdy_s_i(ctl_s[CI_RDY]),
    .cfg_rdy_abort_i(cfg_rdy_abort_i), .addr_i(addr_i),
    .busy_o(busy_o), .done_o(done), .start_rd_o(start_rd_o),
    .cap_addr_o(cap_addr_o), .data_o(data_o), .data_oe_o(data_oe_o)
  );
endmodule

// File: tb/first_addr_latch_tb.sv
module first_addr_latch_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rdy, lat, drst_n, oe_n, cfg;
  logic [22:0] addr;
  logic [15:0] data_o;
  logic        data_oe_o, busy_o, start_rd_o;
  logic [22:0] cap_addr_o;
  int          checks = 0;
  int          fails  = 0;
  bit          ended  = 1'b0;

  always #5 clk = ~clk;

  first_addr_latch u_dut (
    .clk(clk), .rst_n(rst_n), .rdy_i(rdy), .lat_i(lat), .dev_rst_n_i(drst_n),
    .oe_n_i(oe_n), .cfg_rdy_abort_i(cfg), .addr_i(addr),
    .data_o(data_o), .data_oe_o(data_oe_o), .busy_o(busy_o),
    .cap_addr_o(cap_addr_o), .start_rd_o(start_rd_o)
  );

  function automatic logic [22:0] pat(input logic [22:0] seed, input int k);
    return seed + 23'(k) * 23'h010203;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Trigger was driven at the current falling edge. kind: 1 lat low, 2 ready low, 3 oe high.
  task automatic observe(input int abort_at, input int kind, input bit exp_done,
                         input logic [22:0] exp_cap, input logic [22:0] seed, input string req);
    int nb = 0, np = 0;
    bit bad_data = 1'b0;
    addr = pat(seed, 0);
    for (int k = 1; k <= 9; k++) begin
      @(posedge clk);
      @(negedge clk);
      if (busy_o) nb++;
      if (start_rd_o) np++;
      if (busy_o && (data_o != 16'hFFFF || !data_oe_o)) bad_data = 1'b1;
      if (!busy_o && (data_o != 16'h0 || data_oe_o)) bad_data = 1'b1;
      if (exp_done && k == 2) chk(!busy_o, {req, " R2 not before third edge"}, busy_o, 0);
      if (exp_done && k == 3) chk(busy_o,  {req, " R2 busy at third edge"}, busy_o, 1);
      if (exp_done && k == 7) chk(start_rd_o, {req, " R8 strobe timing"}, start_rd_o, 1);
      if (k == abort_at) begin
        case (kind)
          1: lat  = 1'b0;
          2: rdy  = 1'b0;
          3: oe_n = 1'b1;
          default: ;
        endcase
      end
      addr = pat(seed, k);
    end
    chk(!bad_data, {req, " R6 data bus"}, bad_data, 0);
    if (exp_done) begin
      chk(nb == 4, {req, " R6 busy length"}, nb, 4);
      chk(np == 1, {req, " R8 single strobe"}, np, 1);
      chk(cap_addr_o == pat(seed, 4), {req, " R7 captured address"}, cap_addr_o, pat(seed, 4));
    end else begin
      chk(np == 0, {req, " no strobe"}, np, 0);
      chk(cap_addr_o == exp_cap, {req, " R9 address kept"}, cap_addr_o, exp_cap);
    end
  endtask

  task automatic idle_ready();
    rdy = 1'b0; lat = 1'b1; drst_n = 1'b1; oe_n = 1'b0; cfg = 1'b0;
    cycles(5);
  endtask

  task automatic t_reset();
    chk(!busy_o && !start_rd_o && !data_oe_o && data_o == 0, "R1 idle outputs", busy_o, 0);
    chk(cap_addr_o == 0, "R1 address cleared", cap_addr_o, 0);
  endtask

  task automatic t_por_oe_last();
    int nb = 0;
    oe_n = 1'b1; rdy = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (busy_o) nb++;
    end
    chk(nb == 0, "R3 no start with output enable high", nb, 0);
    oe_n = 1'b0;
    observe(0, 0, 1'b1, 0, 23'h123450, "R4 oe fall after ready");
  endtask

  task automatic t_post_por();
    logic [22:0] prev = cap_addr_o;
    oe_n = 1'b1;
    cycles(4);
    oe_n = 1'b0;
    observe(0, 0, 1'b0, prev, 23'h0ABCDE, "R5 oe fall ignored");
    rdy = 1'b0;
    cycles(4);
    rdy = 1'b1;
    observe(0, 0, 1'b1, 0, 23'h3C0F00, "R5 ready rise");
  endtask

  task automatic t_cond();
    logic [22:0] prev = cap_addr_o;
    idle_ready();
    drst_n = 1'b0;
    cycles(3);
    rdy = 1'b1;
    observe(0, 0, 1'b0, prev, 23'h111111, "R3 device reset low");
    idle_ready();
    lat = 1'b0;
    cycles(3);
    rdy = 1'b1;
    observe(0, 0, 1'b0, prev, 23'h222222, "R3 latch low");
  endtask

  task automatic t_abort(input int kind, input string req);
    logic [22:0] prev;
    idle_ready();
    prev = cap_addr_o;
    rdy = 1'b1;
    observe(3, kind, 1'b0, prev, 23'h555000, req);
  endtask

  task automatic t_cfg();
    logic [22:0] prev;
    idle_ready();
    cfg = 1'b1;
    prev = cap_addr_o;
    rdy = 1'b1;
    observe(3, 2, 1'b0, prev, 23'h600060, "R10 ready low aborts");
    idle_ready();
    rdy = 1'b1;
    observe(3, 2, 1'b1, 0, 23'h0700F0, "R10 ready low ignored");
  endtask

  task automatic t_reset_por();
    rst_n = 1'b0;
    #3;
    chk(!busy_o && cap_addr_o == 0, "R1 async reset", cap_addr_o, 0);
    rdy = 1'b1; oe_n = 1'b1; lat = 1'b1; drst_n = 1'b1; cfg = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    cycles(8);
    t_reset();
    oe_n = 1'b0;
    observe(0, 0, 1'b1, 0, 23'h7ABCD0, "R1 power-on rule restored");
  endtask

  initial begin
    #2_000_000;
    if (!ended) begin
      ended = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rdy = 1'b0; lat = 1'b1; drst_n = 1'b1; oe_n = 1'b1; cfg = 1'b0;
    addr = '0;
    cycles(3);
    rst_n = 1'b1;
    cycles(5);
    t_reset();
    t_por_oe_last();
    t_post_por();
    t_cond();
    t_abort(1, "R9 latch drop");
    t_abort(3, "R9 output enable drop");
    t_cfg();
    t_reset_por();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule